// File: doc/BRIEF.md
# Reversible-Gate Set/Reset Latch

This block models a set/reset storage cell assembled from two controlled-controlled-NOT gates whose target inputs are held at 1, so that each gate computes the NAND of its two controls on its third line. Set and reset enter active-low. The first gate takes the set line and the stored Q-bar. The second takes the reset line and the stored Q. Each gate's pass-through control line carries the state value it consumed out of the cell as a garbage line, so no signal fans out. One clock with the step enable high performs one gate-processing step. Both gates update together from the registered pair, which makes the multi-step settling of the cell visible cycle by cycle.

A direction select turns the block into its reverse reading. In that mode the four right-hand terminals (reverse Q, reverse Q-bar, reverse S, reverse R) map in closed form onto the four left-hand lines (the two constant lines, S and R), and the stored pair is frozen. A settle flag reports whether the next forward step would leave the stored pair unchanged. Clock-level stepping lets a surrounding design count how many steps a given start state needs before it is safe to sample.

Top module: `rev_sr_latch`

## Requirements
- R1: A synchronous reset (rst_i high at a clock edge) loads Q=0, Q-bar=1 after that edge, whatever step_i and rev_i are.
- R2: In forward mode with step_i high and set_n_i = reset_n_i = 1, a stored pair of 01 or 10 (Q, Q-bar) is kept unchanged.
- R3: In forward mode with set_n_i=0 and reset_n_i=1, each step computes Q=1 and Q-bar=NOT Q. From 10 or 11 the pair is 10 after one step. From 01 or 00 it passes through 11 and is 10 after the second step.
- R4: In forward mode with set_n_i=1 and reset_n_i=0, each step computes Q-bar=1 and Q=NOT Q-bar. From 01 or 11 the pair is 01 after one step. From 10 or 00 it passes through 11 and is 01 after the second step.
- R5: In forward mode with set_n_i = reset_n_i = 0, the pair becomes 11 after one step and stays 11.
- R6: In forward mode with set_n_i = reset_n_i = 1, a stored 00 becomes 11 and a stored 11 becomes 00 on every step.
- R7: With step_i low, the stored pair does not change.
- R8: settled_o is 1 exactly when the pair the next forward step would produce from the present inputs equals the stored pair. In reverse mode settled_o is 1.
- R9: With rev_i high, the stored pair is frozen and lhs_o = {c1a, c1b, S, R} (bit 3 down to bit 0). S equals set_n_i and R equals reset_n_i, both read as the reverse-side S and R. For (rev_q_i, rev_qb_i): 00 gives c1a=0, c1b=0; 10 gives c1a=S, c1b=1; 01 gives c1a=1, c1b=R; 11 gives c1a=S, c1b=R.
- R10: With rev_i low, lhs_o is 0000.
- R11: garb_o[1] carries the stored Q (the control line of the reset gate) and garb_o[0] carries the stored Q-bar (the control line of the set gate).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| set_n_i | input | 1 | Active-low set (reverse-side S in reverse mode) |
| reset_n_i | input | 1 | Active-low reset (reverse-side R in reverse mode) |
| rev_i | input | 1 | Direction select, 1 = reverse mapping |
| step_i | input | 1 | Performs one gate-processing step at the clock edge |
| rev_q_i | input | 1 | Reverse-side Q terminal |
| rev_qb_i | input | 1 | Reverse-side Q-bar terminal |
| q_o | output | 1 | Stored Q |
| qb_o | output | 1 | Stored Q-bar |
| garb_o | output | 2 | Garbage lines {Q, Q-bar} |
| settled_o | output | 1 | Next step leaves the pair unchanged |
| lhs_o | output | 4 | Reverse-mode left-hand lines {c1a, c1b, S, R} |

## Verification
The stored pair and the garbage lines change one clock edge after a step is applied. settled_o and lhs_o are combinational. They follow the inputs in the same cycle and the stored pair as it stands after the edge. Every check therefore drives its inputs at a falling edge and samples shortly after the next rising edge, with the inputs still applied. Each expected value is worked out from the stepped NAND equations for the pair that the previous rows left behind. Multi-step set and reset from 00, 01, 10 and 11 are followed one row per step, so the transient 11 is checked on the step where it appears.

// File: rtl/rsl_pkg.sv
package rsl_pkg;

   typedef struct packed {
      logic q;
      logic qb;
   } pair_t;

   typedef struct packed {
      logic c1a;
      logic c1b;
      logic s;
      logic r;
   } lhs_t;

   localparam pair_t PAIR_ZERO = '{q: 1'b0, qb: 1'b0};
   localparam lhs_t  LHS_ZERO  = '{c1a: 1'b0, c1b: 1'b0, s: 1'b0, r: 1'b0};

endpackage

// File: rtl/rsl_toffoli_gate.sv
// Controlled-controlled-NOT: target line becomes (x AND y) XOR z, control y passes through.
module rsl_toffoli_gate #(
   parameter int FORM = 0   // 0: xor form, 1: mux form
) (
   input  logic x_i,
   input  logic y_i,
   input  logic z_i,
   output logic y_o,
   output logic z_o
);
   logic both;
   assign both = x_i & y_i;
   assign y_o  = y_i;

   generate
      if (FORM == 0) begin : g_xor
         assign z_o = both ^ z_i;
      end else begin : g_mux
         assign z_o = z_i ? ~both : both;
      end
   endgenerate
endmodule

// File: rtl/rsl_fwd_step.sv
// One forward gate-processing step of the crossed pair of target-tied gates.
module rsl_fwd_step
   import rsl_pkg::*;
#(
   parameter int GATE_FORM = 0
) (
   input  logic  set_n_i,
   input  logic  reset_n_i,
   input  pair_t cur_i,
   output pair_t nxt_o,
   output logic [1:0] garb_o
);
   localparam logic TIE_TARGET = 1'b1;

   logic nq, nqb, pass_qb, pass_q;

   rsl_toffoli_gate #(.FORM(GATE_FORM)) u_set_gate (
      .x_i(set_n_i), .y_i(cur_i.qb), .z_i(TIE_TARGET),
      .y_o(pass_qb), .z_o(nq)
   );

   rsl_toffoli_gate #(.FORM(GATE_FORM)) u_rst_gate (
      .x_i(reset_n_i), .y_i(cur_i.q), .z_i(TIE_TARGET),
      .y_o(pass_q), .z_o(nqb)
   );

   assign nxt_o  = '{q: nq, qb: nqb};
   assign garb_o = {pass_q, pass_qb};
endmodule

// File: rtl/rsl_reverse_map.sv
// Closed-form mapping of right-hand terminals onto the left-hand lines.
module rsl_reverse_map
   import rsl_pkg::*;
(
   input  logic rq_i,
   input  logic rqb_i,
   input  logic rs_i,
   input  logic rr_i,
   output lhs_t lhs_o
);
   always_comb begin
      lhs_o.s   = rs_i;
      lhs_o.r   = rr_i;
      lhs_o.c1a = rq_i  ? rs_i : rqb_i;
      lhs_o.c1b = rqb_i ? rr_i : rq_i;
   end
endmodule

// File: rtl/rev_sr_latch.sv
module rev_sr_latch
   import rsl_pkg::*;
#(
   parameter bit RST_Q     = 1'b0,
   parameter bit RST_QB    = 1'b1,
   parameter int GATE_FORM = 0
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic       set_n_i,
   input  logic       reset_n_i,
   input  logic       rev_i,
   input  logic       step_i,
   input  logic       rev_q_i,
   input  logic       rev_qb_i,
   output logic       q_o,
   output logic       qb_o,
   output logic [1:0] garb_o,
   output logic       settled_o,
   output logic [3:0] lhs_o
);
   localparam pair_t RST_PAIR = '{q: RST_Q, qb: RST_QB};

   generate
      if (RST_Q == RST_QB) begin : g_bad_rst
         $error("reset pair must be complementary");
      end
      if (GATE_FORM < 0 || GATE_FORM > 1) begin : g_bad_form
         $error("GATE_FORM must be 0 or 1");
      end
   endgenerate

   pair_t pair_r, pair_nxt;
   lhs_t  lhs_map;
   logic  fwd_step;

   rsl_fwd_step #(.GATE_FORM(GATE_FORM)) u_step (
      .set_n_i(set_n_i), .reset_n_i(reset_n_i),
      .cur_i(pair_r), .nxt_o(pair_nxt), .garb_o(garb_o)
   );

   rsl_reverse_map u_rev (
      .rq_i(rev_q_i), .rqb_i(rev_qb_i),
      .rs_i(set_n_i), .rr_i(reset_n_i),
      .lhs_o(lhs_map)
   );

   assign fwd_step = step_i & ~rev_i;

   always_ff @(posedge clk_i) begin
      if (rst_i)         pair_r <= RST_PAIR;
      else if (fwd_step) pair_r <= pair_nxt;
   end

   assign q_o       = pair_r.q;
   assign qb_o      = pair_r.qb;
   assign settled_o = rev_i | (pair_nxt == pair_r);
   assign lhs_o     = rev_i ? lhs_map : LHS_ZERO;
endmodule

// File: rtl/rev_sr_latch_chk.sv
module rev_sr_latch_chk (
   input logic       clk_i,
   input logic       rst_i,
   input logic       set_n_i,
   input logic       reset_n_i,
   input logic       rev_i,
   input logic       step_i,
   input logic       q_o,
   input logic       qb_o,
   input logic       settled_o
);
   // R1
   a_r1_reset_pair: assert property (@(posedge clk_i)
      rst_i |=> (!q_o && qb_o));

   // R7
   a_r7_idle_holds: assert property (@(posedge clk_i) disable iff (rst_i)
      !step_i |=> $stable({q_o, qb_o}));

   // R9
   a_r9_reverse_freezes: assert property (@(posedge clk_i) disable iff (rst_i)
      rev_i |=> $stable({q_o, qb_o}));

   // R5
   a_r5_both_active: assert property (@(posedge clk_i) disable iff (rst_i)
      (step_i && !rev_i && !set_n_i && !reset_n_i) |=> (q_o && qb_o));

   // R3
   a_r3_set_drives_q: assert property (@(posedge clk_i) disable iff (rst_i)
      (step_i && !rev_i && !set_n_i && reset_n_i) |=> q_o);

   // R4
   a_r4_reset_drives_qb: assert property (@(posedge clk_i) disable iff (rst_i)
      (step_i && !rev_i && set_n_i && !reset_n_i) |=> qb_o);

   // R2
   a_r2_hold_meaningful: assert property (@(posedge clk_i) disable iff (rst_i)
      (step_i && !rev_i && set_n_i && reset_n_i && (q_o != qb_o)) |=> $stable({q_o, qb_o}));

   // R8
   a_r8_settled_means_stable: assert property (@(posedge clk_i) disable iff (rst_i)
      settled_o |=> $stable({q_o, qb_o}));
endmodule

bind rev_sr_latch rev_sr_latch_chk u_chk (
   .clk_i(clk_i), .rst_i(rst_i), .set_n_i(set_n_i), .reset_n_i(reset_n_i),
   .rev_i(rev_i), .step_i(step_i), .q_o(q_o), .qb_o(qb_o), .settled_o(settled_o)
);

// File: tb/rev_sr_latch_tb_top.sv
`timescale 1ns/1ps
module rev_sr_latch_tb_top;
   logic clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic rst, set_n, reset_n, rev, step, rq, rqb;
   logic q, qb, settled;
   logic [1:0] garb;
   logic [3:0] lhs;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   rev_sr_latch dut_i (
      .clk_i(clk), .rst_i(rst), .set_n_i(set_n), .reset_n_i(reset_n),
      .rev_i(rev), .step_i(step), .rev_q_i(rq), .rev_qb_i(rqb),
      .q_o(q), .qb_o(qb), .garb_o(garb), .settled_o(settled), .lhs_o(lhs)
   );

   // rst sn rn rev step rq rqb | q qb settled | lhs | requirement number
   localparam int NV = 25;
   localparam logic [17:0] VEC [0:NV-1] = '{
      18'b1_1_1_0_1_0_0_0_1_1_0000_0001, // R1 reset -> 01
      18'b0_1_1_0_1_0_0_0_1_1_0000_0010, // R2 hold 01
      18'b0_0_1_0_1_0_0_1_1_0_0000_0011, // R3 set from 01: 11
      18'b0_0_1_0_1_0_0_1_0_1_0000_0011, // R3 then 10
      18'b0_0_1_0_1_0_0_1_0_1_0000_0011, // R3 set from 10 stays
      18'b0_1_1_0_1_0_0_1_0_1_0000_0010, // R2 hold 10
      18'b0_1_0_0_1_0_0_1_1_0_0000_0100, // R4 reset from 10: 11
      18'b0_1_0_0_1_0_0_0_1_1_0000_0100, // R4 then 01
      18'b0_0_1_0_0_0_0_0_1_0_0000_0111, // R7 no step; R8 settled low
      18'b0_0_0_0_1_0_0_1_1_1_0000_0101, // R5 both asserted -> 11
      18'b0_0_0_0_1_0_0_1_1_1_0000_0101, // R5 stays 11
      18'b0_1_1_0_1_0_0_0_0_0_0000_0110, // R6 11 -> 00
      18'b0_1_1_0_1_0_0_1_1_0_0000_0110, // R6 00 -> 11
      18'b0_1_1_0_1_0_0_0_0_0_0000_0110, // R6 11 -> 00
      18'b0_0_1_0_1_0_0_1_1_0_0000_0011, // R3 set from 00: 11
      18'b0_0_1_0_1_0_0_1_0_1_0000_0011, // R3 then 10
      18'b0_1_0_1_1_1_0_1_0_1_1110_1001, // R9 rev Q=1,Qb=0
      18'b0_0_1_1_1_0_1_1_0_1_1101_1001, // R9 rev Q=0,Qb=1
      18'b0_1_1_1_1_0_0_1_0_1_0011_1001, // R9 rev 00
      18'b0_0_1_1_1_1_1_1_0_1_0101_1001, // R9 rev 11
      18'b1_0_1_0_1_0_0_0_1_0_0000_0001, // R1 reset wins over set
      18'b0_0_0_0_1_0_0_1_1_1_0000_0101, // R5 -> 11
      18'b0_1_1_0_1_0_0_0_0_0_0000_0110, // R6 -> 00
      18'b0_1_0_0_1_0_0_1_1_0_0000_0100, // R4 reset from 00: 11
      18'b0_1_0_0_1_0_0_0_1_1_0000_0100  // R4 then 01
   };

   task automatic check(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic r, input logic s, input logic rn, input logic v,
                        input logic st, input logic a, input logic b);
      @(negedge clk);
      rst = r; set_n = s; reset_n = rn; rev = v; step = st; rq = a; rqb = b;
      @(posedge clk);
      #2;
   endtask

   initial begin
      rst = 1'b1; set_n = 1'b1; reset_n = 1'b1; rev = 1'b0; step = 1'b0; rq = 1'b0; rqb = 1'b0;
      for (int i = 0; i < NV; i++) begin
         logic [17:0] v;
         string tag;
         v = VEC[i];
         drive(v[17], v[16], v[15], v[14], v[13], v[12], v[11]);
         tag = $sformatf("R%0d(vec %0d)", v[3:0], i);
         check(tag, "pair", {2'b00, q, qb}, {2'b00, v[10], v[9]});
         check(tag, "settled_o R8", {3'b000, settled}, {3'b000, v[8]});
         check(tag, "lhs_o R9/R10", lhs, v[7:4]);
         check("R11", "garb_o", {2'b00, garb}, {2'b00, q, qb});
      end

      // Directed: reset applies with step low and reverse mode on (R1)
      drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);  // 01 -> 11
      drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);  // -> 10
      check("R3", "pair before reset", {2'b00, q, qb}, 4'b0010);
      drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      check("R1", "reset with step low, reverse on", {2'b00, q, qb}, 4'b0001);
      check("R8", "settled in reverse", {3'b000, settled}, 4'b0001);
      // Reset corner from 11 in one step (R4)
      drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);  // -> 11
      drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);  // -> 01
      check("R4", "reset from 11", {2'b00, q, qb}, 4'b0001);
      // Set corner from 11 in one step (R3)
      drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);  // -> 11
      drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);  // -> 10
      check("R3", "set from 11", {2'b00, q, qb}, 4'b0010);
      // Reverse inputs cannot disturb the state (R9)
      drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
      check("R9", "pair frozen in reverse", {2'b00, q, qb}, 4'b0010);
      check("R9", "lhs 11 terminals", lhs, 4'b0000);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule